// File: doc/BRIEF.md
# SPI Controller with Mode-Fault Supervisor

This block is a byte-wide SPI shift engine that can act as bus master or as a selected slave. Software drives it through a small register bus: a control register sets the operating mode, a status register reports progress, and a data register loads the outgoing byte and returns the received one. The serial pins are split into output value, output enable and input, so the pads stay outside the block. The serial format is fixed: SCK idles low, the input is sampled on the rising edge, the shift happens on the falling edge, and the MSB goes first. In master mode each SCK half period lasts `HALF_DIV` clock cycles.

A supervisor watches the active-low slave-select input while the block is master. If another device pulls select low, the supervisor sets a sticky fault flag. The block then behaves as a slave whose pins are all released, and any transfer in flight is dropped. The flag clears only through a handshake: software first reads status while the flag is visible, then writes the control register. If select goes low again between the read and the write, the handshake is cancelled. A module-enable bit holds the shift engine idle, while the registers stay accessible. All data moves through the register bus, so the block has no stream port.

Top module: `spi_mf`

## Requirements
- R1: With enable (control bit 0), master (control bit 1) and fault-enable (control bit 2) all set, a low on `ss_n_i` sets the fault flag (status bit 0) at the third rising clock edge after the low is first sampled.
- R2: With fault-enable clear, `ss_n_i` is ignored in master mode: the fault flag stays 0 and a master transfer completes normally.
- R3: In slave mode (control bit 1 clear), including bidirectional slave mode, `ss_n_i` never sets the fault flag.
- R4: While the fault flag is set, `sck_oe`, `mosi_oe` and `miso_oe` are all 0.
- R5: A fault aborts the transfer in progress. The shift engine returns to idle (status bit 2 clear) and the partial byte is never captured: rx-full (status bit 1) stays 0.
- R6: A fault clears the bidirectional output-enable control bit (bit 4). Control bit 3 selects the bidirectional mode, in which the master shares `mosi` for in and out.
- R7: The fault flag clears only when a control write (address 0) follows a status read (address 1) that saw the flag set. A control write with no such read leaves the flag set.
- R8: A fault event between that status read and the control write cancels the handshake, and the flag stays set.
- R9: While the fault flag is set, control bit 1 reads back as 0. After the flag clears, the stored master setting takes effect again.
- R10: With the enable bit clear, no transfer starts, all output enables are 0, and the control register stays readable and writable.
- R11: In master mode, writing the data register (address 2) while idle sends that byte. After 8 SCK cycles the received byte is readable at address 2 and rx-full is set. Reading address 2 clears rx-full.
- R12: In slave mode, a byte loaded while select is high goes out on `miso_o`, MSB first, while select is low. The 8 bits received on `mosi_i` are captured into the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| ss_n_i | input | 1 | Slave-select input, active low |
| sck_i | input | 1 | Serial clock input (slave) |
| sck_o | output | 1 | Serial clock output (master) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | MOSI pin input |
| mosi_o | output | 1 | MOSI pin output |
| mosi_oe | output | 1 | MOSI pin output enable |
| miso_i | input | 1 | MISO pin input |
| miso_o | output | 1 | MISO pin output |
| miso_oe | output | 1 | MISO pin output enable |

## Verification
The assertions assume that `ss_n_i` and `sck_i` are asynchronous and are only seen through the two-flop synchronisers. They also assume that only one of the read and write strobes is high in a cycle. The stimulus drives every pin and strobe on the falling clock edge. It holds `sck_i` levels for eight cycles so the synchronised edges fall well inside each bit. It changes the control register only while no transfer is in flight, except in the deliberate abort case.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int C_EN   = 0;  // module enable
  localparam int C_MST  = 1;  // master select
  localparam int C_FEN  = 2;  // fault detection enable
  localparam int C_BID  = 3;  // bidirectional pin mode
  localparam int C_BOE  = 4;  // bidirectional output enable
  localparam int CTRL_W = 5;
endpackage

// File: rtl/spi_mf_sync.sv
module spi_mf_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{INIT}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_mf_engine.sv
module spi_mf_engine #(
  parameter int W        = 8,
  parameter int HALF_DIV = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         abort,
  input  logic         is_master,
  input  logic         start,
  input  logic         load,
  input  logic [W-1:0] wdata,
  input  logic         sel_low,
  input  logic         sck_in,
  input  logic         din,
  output logic         sck_out,
  output logic         dout,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_byte
);
  localparam int CW = $clog2(W);
  localparam int TW = $clog2(HALF_DIV) + 1;

  logic [W-1:0]  sr;
  logic          rxbit;
  logic [CW-1:0] bits;
  logic [TW-1:0] tick;
  logic          sck_prev;

  wire s_rise = !is_master && sel_low && sck_in && !sck_prev;
  wire s_fall = !is_master && sel_low && !sck_in && sck_prev;
  wire m_tick = is_master && busy && (tick == TW'(HALF_DIV - 1));
  wire rise   = (m_tick && !sck_out) || s_rise;
  wire fall   = (m_tick && sck_out) || s_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0; rxbit <= 1'b0; bits <= '0; tick <= '0; sck_prev <= 1'b0;
      sck_out <= 1'b0; busy <= 1'b0; done <= 1'b0; rx_byte <= '0;
    end else if (!run || abort) begin
      busy <= 1'b0; sck_out <= 1'b0; bits <= '0; tick <= '0;
      done <= 1'b0; sck_prev <= sck_in;
    end else begin
      done     <= 1'b0;
      sck_prev <= sck_in;
      if (is_master) begin
        if (start && !busy) begin
          sr <= wdata; busy <= 1'b1; tick <= '0; sck_out <= 1'b0; bits <= '0;
        end else if (busy) begin
          tick <= m_tick ? '0 : tick + 1'b1;
        end
      end else begin
        sck_out <= 1'b0;
        if (load) sr <= wdata;
        if (!sel_low) begin
          bits <= '0;
          busy <= 1'b0;
        end else if (s_rise) begin
          busy <= 1'b1;
        end
      end
      if (rise) begin
        rxbit <= din;
        if (is_master) sck_out <= 1'b1;
      end
      if (fall) begin
        sr <= {sr[W-2:0], rxbit};
        if (is_master) sck_out <= 1'b0;
        if (bits == CW'(W - 1)) begin
          bits    <= '0;
          busy    <= 1'b0;
          done    <= 1'b1;
          rx_byte <= {sr[W-2:0], rxbit};
        end else begin
          bits <= bits + 1'b1;
        end
      end
    end
  end

  assign dout = sr[W-1];
endmodule

// File: rtl/spi_mf_supervisor.sv
module spi_mf_supervisor (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_evt,
  input  logic stat_rd,
  input  logic ctrl_wr,
  output logic modf,
  output logic armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modf  <= 1'b0;
      armed <= 1'b0;
    end else if (fault_evt) begin
      modf  <= 1'b1;
      armed <= 1'b0;
    end else if (ctrl_wr) begin
      if (armed) modf <= 1'b0;
      armed <= 1'b0;
    end else if (stat_rd && modf) begin
      armed <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_mf.sv
module spi_mf #(
  parameter int W        = 8,
  parameter int HALF_DIV = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   bus_addr,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         ss_n_i,
  input  logic         sck_i,
  output logic         sck_o,
  output logic         sck_oe,
  input  logic         mosi_i,
  output logic         mosi_o,
  output logic         mosi_oe,
  input  logic         miso_i,
  output logic         miso_o,
  output logic         miso_oe
);
  import spi_mf_pkg::*;

  logic [CTRL_W-1:0] ctrl_q;
  logic [W-1:0]      rx_data;
  logic              rx_full;
  logic              ss_sync, sck_sync, modf, armed;
  logic              busy, done, dout, sck_eng;
  logic [W-1:0]      rx_byte;

  spi_mf_sync #(.STAGES(2), .INIT(1'b1)) u_ss_sync (
    .clk(clk), .rst_n(rst_n), .d(ss_n_i), .q(ss_sync));
  spi_mf_sync #(.STAGES(2), .INIT(1'b0)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .d(sck_i), .q(sck_sync));

  wire ss_low     = !ss_sync;
  wire en         = ctrl_q[C_EN];
  wire bidir      = ctrl_q[C_BID];
  wire bid_oe     = ctrl_q[C_BOE];
  wire master_eff = ctrl_q[C_MST] && !modf;
  wire ctrl_wr    = bus_wr && (bus_addr == REG_CTRL);
  wire data_wr    = bus_wr && (bus_addr == REG_DATA);
  wire stat_rd    = bus_rd && (bus_addr == REG_STAT);
  wire data_rd    = bus_rd && (bus_addr == REG_DATA);
  wire fault_evt  = en && ctrl_q[C_MST] && ctrl_q[C_FEN] && ss_low;
  wire out_ok     = !bidir || bid_oe;

  spi_mf_supervisor u_sup (
    .clk(clk), .rst_n(rst_n), .fault_evt(fault_evt), .stat_rd(stat_rd),
    .ctrl_wr(ctrl_wr), .modf(modf), .armed(armed));

  wire din = master_eff ? (bidir ? mosi_i : miso_i) : (bidir ? miso_i : mosi_i);

  spi_mf_engine #(.W(W), .HALF_DIV(HALF_DIV)) u_eng (
    .clk(clk), .rst_n(rst_n), .run(en), .abort(modf || fault_evt),
    .is_master(master_eff), .start(data_wr && en && master_eff),
    .load(data_wr && !master_eff && !ss_low), .wdata(bus_wdata),
    .sel_low(ss_low), .sck_in(sck_sync), .din(din), .sck_out(sck_eng),
    .dout(dout), .busy(busy), .done(done), .rx_byte(rx_byte));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      rx_data <= '0;
      rx_full <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (fault_evt) ctrl_q[C_BOE] <= 1'b0;
      if (done) begin
        rx_data <= rx_byte;
        rx_full <= 1'b1;
      end else if (data_rd) begin
        rx_full <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (bus_addr)
      REG_CTRL: begin
        bus_rdata = '0;
        bus_rdata[CTRL_W-1:0] = ctrl_q;
        bus_rdata[C_MST] = master_eff;
      end
      REG_STAT: bus_rdata = W'({busy, rx_full, modf});
      REG_DATA: bus_rdata = rx_data;
      default:  bus_rdata = '0;
    endcase
  end

  assign sck_o   = sck_eng;
  assign sck_oe  = en && master_eff;
  assign mosi_o  = dout;
  assign mosi_oe = en && master_eff && out_ok;
  assign miso_o  = dout;
  assign miso_oe = en && !ctrl_q[C_MST] && !modf && ss_low && out_ok;
endmodule

// File: rtl/spi_mf_chk.sv
module spi_mf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bus_addr,
  input logic       bus_wr,
  input logic [4:0] ctrl_q,
  input logic       ss_low,
  input logic       modf,
  input logic       rx_full,
  input logic       busy,
  input logic       sck_oe,
  input logic       mosi_oe,
  input logic       miso_oe
);
  wire ctrl_wr = bus_wr && (bus_addr == 2'd0);

  a_r1_fault_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && ctrl_q[1] && ctrl_q[2] && ss_low) |=> modf);

  a_r2_fen_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[2] && !modf && !ctrl_wr) |=> !modf);

  a_r3_slave_immune: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[1] && !modf && !ctrl_wr) |=> !modf);

  a_r4_pins_released: assert property (@(posedge clk) disable iff (!rst_n)
    modf |-> (!sck_oe && !mosi_oe && !miso_oe));

  a_r5_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (modf && !rx_full) |=> !rx_full);

  a_r5_engine_idle: assert property (@(posedge clk) disable iff (!rst_n)
    modf |=> !busy);

  a_r6_bidir_oe_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf) |-> !ctrl_q[4]);

  a_r7_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (modf && !ctrl_wr) |=> modf);

  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |-> (!sck_oe && !mosi_oe && !miso_oe));
endmodule

bind spi_mf spi_mf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .ctrl_q(ctrl_q), .ss_low(ss_low), .modf(modf), .rx_full(rx_full),
  .busy(busy), .sck_oe(sck_oe), .mosi_oe(mosi_oe), .miso_oe(miso_oe));

// File: tb/test_spi_mf.sv
`timescale 1ns/1ps
module test_spi_mf;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd3;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ss_n_i = 1'b1, sck_i = 1'b0, mosi_i = 1'b0;
  logic       sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic       loop = 1'b1, miso_drv = 1'b0;
  wire        miso_i = loop ? mosi_o : miso_drv;
  int         n_run = 0, n_fail = 0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  spi_mf i_spi_mf (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ss_n_i(ss_n_i), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i),
    .miso_o(miso_o), .miso_oe(miso_oe));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_addr = 2'd3;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0; bus_addr = 2'd3;
  endtask

  task automatic t_reset;
    rd(2'd0, v); check("R10 reset ctrl", v, 8'h00);
    rd(2'd1, v); check("R10 reset stat", v, 8'h00);
    check("R10 reset oe", {5'b0, sck_oe, mosi_oe, miso_oe}, 8'h00);
  endtask

  task automatic t_disabled;
    wr(2'd0, 8'h02); wr(2'd2, 8'h77); idle(4);
    check("R10 no sck drive", {7'b0, sck_oe}, 8'h00);
    rd(2'd1, v); check("R10 not busy", v, 8'h00);
    rd(2'd0, v); check("R10 ctrl readable", v, 8'h02);
  endtask

  task automatic t_master_xfer;
    wr(2'd0, 8'h07); wr(2'd2, 8'hA5); idle(2);
    rd(2'd1, v); check("R11 busy during transfer", v & 8'h04, 8'h04);
    idle(50);
    rd(2'd1, v); check("R11 rx_full set", v, 8'h02);
    rd(2'd2, v); check("R11 loopback byte", v, 8'hA5);
    rd(2'd1, v); check("R11 rx_full cleared by read", v, 8'h00);
  endtask

  task automatic t_fault_in_xfer;
    wr(2'd0, 8'h07); wr(2'd2, 8'h3C); idle(6);
    ss_n_i = 1'b0; idle(4);
    check("R4 pins released", {5'b0, sck_oe, mosi_oe, miso_oe}, 8'h00);
    rd(2'd0, v); check("R9 master reads 0", v, 8'h05);
    ss_n_i = 1'b1; idle(4);
    wr(2'd0, 8'h07);
    rd(2'd1, v); check("R7 write without read keeps flag; R5 idle, no rx", v, 8'h01);
    wr(2'd0, 8'h07); idle(1);
    rd(2'd1, v); check("R7 handshake clears flag", v, 8'h00);
    rd(2'd0, v); check("R9 master restored", v, 8'h07);
    check("R9 sck driven again", {7'b0, sck_oe}, 8'h01);
  endtask

  task automatic t_cancelled_clear;
    wr(2'd0, 8'h07); ss_n_i = 1'b0; idle(4);
    rd(2'd1, v); check("R1 flag set", v & 8'h01, 8'h01);
    idle(2); wr(2'd0, 8'h07);
    rd(2'd1, v); check("R8 clear cancelled by new fault", v & 8'h01, 8'h01);
    ss_n_i = 1'b1; idle(4);
    rd(2'd1, v); wr(2'd0, 8'h07);
    rd(2'd1, v); check("R7 clear after select released", v, 8'h00);
  endtask

  task automatic t_fen_off;
    wr(2'd0, 8'h03); ss_n_i = 1'b0; idle(4);
    wr(2'd2, 8'h5A); idle(50);
    rd(2'd1, v); check("R2 no fault, byte done", v, 8'h02);
    rd(2'd2, v); check("R2 byte received", v, 8'h5A);
    check("R2 sck still driven", {7'b0, sck_oe}, 8'h01);
    ss_n_i = 1'b1; idle(4);
  endtask

  task automatic t_bidir;
    wr(2'd0, 8'h1F); idle(1);
    check("R6 bidir out enabled", {7'b0, mosi_oe}, 8'h01);
    ss_n_i = 1'b0; idle(4);
    rd(2'd0, v); check("R6 bidir oe cleared", v, 8'h0D);
    ss_n_i = 1'b1; idle(4);
    rd(2'd1, v); wr(2'd0, 8'h0F); idle(1);
    check("R6 mosi input after clear", {7'b0, mosi_oe}, 8'h00);
  endtask

  task automatic t_slave;
    logic [7:0] got;
    loop = 1'b0;
    wr(2'd0, 8'h05); wr(2'd2, 8'h3C);
    ss_n_i = 1'b0; idle(4);
    check("R12 miso driven", {7'b0, miso_oe}, 8'h01);
    for (int i = 7; i >= 0; i--) begin
      mosi_i = v_pat(i); idle(8);
      got[i] = miso_o;
      sck_i = 1'b1; idle(8);
      sck_i = 1'b0; idle(8);
    end
    ss_n_i = 1'b1; idle(4);
    check("R12 slave sent byte", got, 8'h3C);
    rd(2'd1, v); check("R3 no fault in slave", v, 8'h02);
    rd(2'd2, v); check("R12 slave received byte", v, 8'hC3);
    wr(2'd0, 8'h0D); ss_n_i = 1'b0; idle(6);
    rd(2'd1, v); check("R3 bidir slave no fault", v, 8'h00);
    ss_n_i = 1'b1; loop = 1'b1;
  endtask

  function automatic logic v_pat(input int i);
    logic [7:0] p = 8'hC3;
    return p[i];
  endfunction

  initial begin
    idle(3); rst_n = 1'b1; idle(2);
    t_reset();
    t_disabled();
    t_master_xfer();
    t_fault_in_xfer();
    t_cancelled_clear();
    t_fen_off();
    t_bidir();
    t_slave();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #500000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule